// File: doc/BRIEF.md
# Discriminator Edge Time Tagger

This block turns the level changes on a bank of asynchronous discriminator trigger lines into 80-bit time-tagged words. Each line first passes through a two-flop synchronizer. A change of the synchronized level against its value one cycle earlier counts as an edge, and each edge becomes one record. The record holds the edge polarity, a per-channel event number, a coarse timestamp, and the fine-time value that an external delay-line TDC supplies for that channel.

The coarse timestamp counts clock cycles. It restarts on the run-start pulse and on the front-end chip's own overflow strobe, so it stays in step with the chip's counter. Records wait in a small FIFO per channel. A round-robin arbiter moves them, one at a time, into a single output stage that uses valid/ready flow control.

Back-pressure rules: `out_valid` and `out_word` stay constant while `out_ready` is low. A word transfers on any rising edge where both `out_valid` and `out_ready` are high. When the output is stalled, records collect in the channel FIFOs. Once a FIFO is full, further edges on that channel are lost and counted.

Top module: `disc_edge_tagger`

## Requirements
- R1: Every output word carries the following fields. Bits [79:78] hold 2'b10. Bit 77 is the polarity. Bits [76:73] hold the channel number. Bits [72:48] hold the 25-bit event number. Bits [47:22] hold the 26-bit coarse timestamp. Bits [21:16] hold the 6-bit fine time. Bits [15:11] are zero. Bits [10:8] carry `asic_id` and bits [7:0] carry `card_id`.
- R2: Each rising or falling level change on any enabled trigger input produces exactly one word. The polarity bit is 1 for a rising edge and 0 for a falling edge.
- R3: Suppose a trigger input changes between two clock edges, with the output stage and FIFOs empty and `out_ready` high. `out_valid` is then low after the first three rising edges that follow and high after the fourth.
- R4: The coarse timestamp is cleared by a clock edge that samples `init` high and then rises by one per cycle. A trigger change made in the m-th cycle after that clearing edge (m = 0 for the cycle right after it) is stamped with the value m+2.
- R5: A clock edge that samples `ts_ovf` high clears the coarse timestamp exactly as `init` does, with the same m+2 stamping rule.
- R6: Each channel has its own event number. It is 0 after reset and goes up by one for each edge that is stored. Edges that are dropped or ignored do not advance it. It wraps silently at 2^25.
- R7: The fine-time field is the channel's 6-bit slice of `fine_in` (bits [6c+5:6c] for channel c), sampled in the cycle the edge is detected.
- R8: While `enable` is low, trigger edges are ignored. No word is produced, and neither the event numbers nor the drop counters change. Level changes made while disabled produce no word after `enable` returns high.
- R9: Each channel buffers 4 records in its FIFO, and the output stage holds one more word. An edge that arrives while its channel FIFO is full is dropped. The drop adds one to that channel's 8-bit counter on `drop_cnt` (bits [8c+7:8c]). That counter saturates and is cleared only by reset.
- R10: When several channels hold records, grants go round-robin, beginning with the channel after the one served last. After reset the search starts at channel 0.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R12: After reset, `out_valid` is low and every drop counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the coarse timestamp counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Stream enable; low ignores all edges |
| init | input | 1 | Run-start pulse; clears the coarse timestamp |
| ts_ovf | input | 1 | Front-end timestamp overflow strobe; clears the coarse timestamp |
| trig_in | input | 16 | Asynchronous discriminator trigger lines, one per channel |
| fine_in | input | 96 | Per-channel 6-bit fine time from the external TDC |
| asic_id | input | 3 | Front-end chip number placed in each word |
| card_id | input | 8 | Card number placed in each word |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 80 | Time-tagged edge word |
| drop_cnt | output | 128 | Per-channel saturating 8-bit count of dropped edges |

## Verification
Every result has a fixed distance in rising edges from the stimulus that causes it. A trigger change is synchronized by the second edge, detected and pushed at the third, and shows up on the output at the fourth. Its timestamp is therefore m+2 counted from the clearing edge, and a drop counter moves at the third edge after a change that overflows the FIFO. The bench drives every input on the falling clock edge and samples on later falling edges. It checks latency by counting exactly four such edges, and in the other tests it waits for `out_valid` and compares the whole word or its individual fields. For the ignore and back-pressure cases it holds the stimulus for several cycles and then reads the output port and `drop_cnt`.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int EVW   = 25;
  localparam int TSW   = 26;
  localparam int FTW   = 6;
  localparam int CHF   = 4;
  localparam int ASW   = 3;
  localparam int CDW   = 8;
  localparam int WORDW = 80;

  // one buffered edge: polarity, event number, coarse time, fine time
  typedef struct packed {
    logic           pol;
    logic [EVW-1:0] ev;
    logic [TSW-1:0] ts;
    logic [FTW-1:0] fine;
  } rec_t;

  function automatic logic [WORDW-1:0] pack_word(input rec_t r,
                                                 input logic [CHF-1:0] ch,
                                                 input logic [ASW-1:0] a,
                                                 input logic [CDW-1:0] c);
    return {2'b10, r.pol, ch, r.ev, r.ts, r.fine, 5'b00000, a, c};
  endfunction
endpackage

// File: rtl/dtt_sync_edge.sv
module dtt_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/dtt_fifo.sv
module dtt_fifo #(
  parameter int W     = 58,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/dtt_rr_arb.sv
module dtt_rr_arb #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] last_q;

  always_comb begin
    logic found;
    int   idx;
    found   = 1'b0;
    gnt     = '0;
    gnt_idx = last_q;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        found        = 1'b1;
        gnt[idx]     = 1'b1;
        gnt_idx      = IW'(idx);
      end
    end
  end

  assign any = |req;

  always_ff @(posedge clk) begin
    if (rst)       last_q <= IW'(N - 1);
    else if (take) last_q <= gnt_idx;
  end
endmodule

// File: rtl/disc_edge_tagger.sv
module disc_edge_tagger
  import dtt_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DEPTH = 4,
  parameter int DROPW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 init,
  input  logic                 ts_ovf,
  input  logic [NCH-1:0]       trig_in,
  input  logic [NCH*FTW-1:0]   fine_in,
  input  logic [ASW-1:0]       asic_id,
  input  logic [CDW-1:0]       card_id,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORDW-1:0]     out_word,
  output logic [NCH*DROPW-1:0] drop_cnt
);
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int RECW = $bits(rec_t);

  // coarse time, restarted together with the front-end counter
  logic [TSW-1:0] ts_q;
  always_ff @(posedge clk) begin
    if (rst || init || ts_ovf) ts_q <= '0;
    else                       ts_q <= ts_q + 1'b1;
  end

  logic [NCH-1:0] rise, fall, hit, push, full, empty, pop, gnt;
  rec_t           rec_in  [NCH];
  logic [RECW-1:0] rec_out [NCH];
  logic [EVW-1:0] ev_q    [NCH];
  logic [DROPW-1:0] drop_q [NCH];
  logic [IW-1:0]  gnt_idx;
  logic           any_req, load;

  assign load = any_req & (~out_valid | out_ready);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dtt_sync_edge u_se (
      .clk  (clk),
      .rst  (rst),
      .din  (trig_in[ch]),
      .rise (rise[ch]),
      .fall (fall[ch])
    );

    assign hit[ch]  = enable & (rise[ch] | fall[ch]);
    assign push[ch] = hit[ch] & ~full[ch];
    assign pop[ch]  = gnt[ch] & load;

    assign rec_in[ch] = '{pol:  rise[ch],
                          ev:   ev_q[ch],
                          ts:   ts_q,
                          fine: fine_in[ch*FTW +: FTW]};

    always_ff @(posedge clk) begin
      if (rst) begin
        ev_q[ch]   <= '0;
        drop_q[ch] <= '0;
      end else begin
        if (push[ch]) ev_q[ch] <= ev_q[ch] + 1'b1;
        if (hit[ch] && full[ch] && (drop_q[ch] != '1))
          drop_q[ch] <= drop_q[ch] + 1'b1;
      end
    end

    dtt_fifo #(.W(RECW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push[ch]),
      .din   (rec_in[ch]),
      .pop   (pop[ch]),
      .dout  (rec_out[ch]),
      .empty (empty[ch]),
      .full  (full[ch])
    );

    assign drop_cnt[ch*DROPW +: DROPW] = drop_q[ch];
  end

  dtt_rr_arb #(.N(NCH), .IW(IW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (~empty),
    .take    (load),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any_req)
  );

  rec_t rec_sel;
  assign rec_sel = rec_t'(rec_out[gnt_idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= pack_word(rec_sel, CHF'(gnt_idx), asic_id, card_id);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dtt_check.sv
module dtt_check #(
  parameter int NCH   = 16,
  parameter int DROPW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 enable,
  input logic                 init,
  input logic                 ts_ovf,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [79:0]          out_word,
  input logic [25:0]          ts_q,
  input logic [NCH-1:0]       gnt,
  input logic [NCH*DROPW-1:0] drop_cnt
);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_format_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word[79:78] == 2'b10 && out_word[15:11] == 5'd0));

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (init || ts_ovf) |=> (ts_q == 26'd0));

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(drop_cnt));

  p_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
endmodule

bind disc_edge_tagger dtt_check #(.NCH(NCH), .DROPW(DROPW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .init      (init),
  .ts_ovf    (ts_ovf),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .ts_q      (ts_q),
  .gnt       (gnt),
  .drop_cnt  (drop_cnt)
);

// File: tb/sim_disc_edge_tagger.sv
`timescale 1ns/1ps
module sim_disc_edge_tagger;
  localparam int NCH = 16;
  localparam int DROPW = 8;
  localparam logic [2:0] ASIC = 3'd5;
  localparam logic [7:0] CARD = 8'hA7;

  // {channel, delay m, fine, use overflow strobe}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {4'd0,  8'd0,  6'd5,  1'b0},
    {4'd15, 8'd7,  6'd23, 1'b0},
    {4'd5,  8'd3,  6'd0,  1'b1},
    {4'd5,  8'd12, 6'd63, 1'b0},
    {4'd9,  8'd1,  6'd17, 1'b1},
    {4'd3,  8'd30, 6'd40, 1'b0}
  };

  logic clk = 1'b0;
  logic rst, enable, init, ts_ovf, out_ready, out_valid;
  logic [NCH-1:0] trig_in;
  logic [NCH*6-1:0] fine_in;
  logic [79:0] out_word;
  logic [NCH*DROPW-1:0] drop_cnt;

  int checks = 0;
  int fails = 0;
  int cnt [NCH];
  logic lvl [NCH];

  always #2.5 clk = ~clk;

  disc_edge_tagger u0 (
    .clk(clk), .rst(rst), .enable(enable), .init(init), .ts_ovf(ts_ovf),
    .trig_in(trig_in), .fine_in(fine_in), .asic_id(ASIC), .card_id(CARD),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .drop_cnt(drop_cnt)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic toggle(input int ch);
    lvl[ch] = ~lvl[ch];
    trig_in[ch] = lvl[ch];
  endtask

  task automatic get_word(input string req, output logic [79:0] w);
    w = '0;
    for (int i = 0; i < 60 && !out_valid; i++) @(negedge clk);
    if (!out_valid) begin
      checks++;
      fails++;
      $display("FAIL %s actual=no_word expected=word", req);
    end else begin
      w = out_word;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    trig_in = '0;
    for (int c = 0; c < NCH; c++) begin
      cnt[c] = 0;
      lvl[c] = 1'b0;
    end
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [79:0] w, w2;
    enable = 1'b1; init = 1'b0; ts_ovf = 1'b0; out_ready = 1'b1;
    fine_in = '0;
    @(negedge clk);
    do_reset();

    // R12 reset state
    chk("R12 out_valid", 128'(out_valid), 128'd0);
    chk("R12 drop_cnt", 128'(drop_cnt), 128'd0);

    // vector table: R1 R2 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      int ch, m;
      logic [5:0] f;
      logic [79:0] exp;
      ch = int'(VEC[v][18:15]);
      m  = int'(VEC[v][14:7]);
      f  = VEC[v][6:1];
      fine_in[ch*6 +: 6] = f;
      if (VEC[v][0]) ts_ovf = 1'b1; else init = 1'b1;
      tick(1);
      ts_ovf = 1'b0; init = 1'b0;
      tick(m);
      toggle(ch);
      exp = {2'b10, lvl[ch], 4'(ch), 25'(cnt[ch]), 26'(m + 2), f, 5'b0, ASIC, CARD};
      cnt[ch]++;
      get_word("R1/R2/R4/R5/R6/R7 vector", w);
      chk("R1/R2/R4/R5/R6/R7 vector word", 128'(w), 128'(exp));
    end

    // R3 latency
    tick(2);
    toggle(0);
    tick(3);
    chk("R3 not yet valid", 128'(out_valid), 128'd0);
    tick(1);
    chk("R3 valid at fourth edge", 128'(out_valid), 128'd1);
    get_word("R3", w);
    chk("R3 channel", 128'(w[76:73]), 128'd0);
    cnt[0]++;

    // R8 disable: ignored edges
    enable = 1'b0;
    toggle(1);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (out_valid) chk("R8 no word while disabled", 128'(out_valid), 128'd0);
    end
    chk("R8 no word while disabled", 128'(out_valid), 128'd0);
    chk("R8 drop unchanged", 128'(drop_cnt), 128'd0);
    enable = 1'b1;
    tick(8);
    chk("R8 no word after re-enable", 128'(out_valid), 128'd0);
    toggle(1);
    get_word("R8", w);
    chk("R8 event number unchanged", 128'(w[72:48]), 128'(cnt[1]));
    chk("R8 polarity of new edge", 128'(w[77]), 128'(lvl[1]));
    cnt[1]++;

    // R10 round-robin after reset
    do_reset();
    out_ready = 1'b0;
    toggle(2); toggle(5);
    tick(1);
    toggle(2);
    tick(8);
    out_ready = 1'b1;
    get_word("R10", w);
    chk("R10 first grant ch2", 128'(w[76:73]), 128'd2);
    chk("R10 first rising", 128'(w[77]), 128'd1);
    get_word("R10", w);
    chk("R10 second grant ch5", 128'(w[76:73]), 128'd5);
    get_word("R10", w);
    chk("R10 third grant ch2", 128'(w[76:73]), 128'd2);
    chk("R10 third falling", 128'(w[77]), 128'd0);
    chk("R10 third event number", 128'(w[72:48]), 128'd1);

    // R9 overflow and R11 back-pressure
    out_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      toggle(9);
      tick(1);
    end
    tick(6);
    chk("R9 drop count ch9", 128'(drop_cnt[9*DROPW +: DROPW]), 128'd3);
    chk("R9 other channels no drops", 128'(drop_cnt[8*DROPW +: DROPW]), 128'd0);
    w2 = out_word;
    chk("R11 valid held", 128'(out_valid), 128'd1);
    tick(3);
    chk("R11 word stable", 128'(out_word), 128'(w2));
    chk("R11 valid still held", 128'(out_valid), 128'd1);
    out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      get_word("R9", w);
      chk("R9 buffered event number", 128'(w[72:48]), 128'(k));
      chk("R9 buffered polarity", 128'(w[77]), 128'((k % 2) == 0));
    end
    tick(10);
    chk("R9 nothing beyond capacity", 128'(out_valid), 128'd0);
    toggle(9);
    get_word("R9", w);
    chk("R6/R9 dropped edges not counted", 128'(w[72:48]), 128'd5);
    chk("R9 drop count sticky", 128'(drop_cnt[9*DROPW +: DROPW]), 128'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule